// File: doc/BRIEF.md
# Legacy display address routing decoder

This block looks at each memory or I/O request the processor issues and decides whether the request should be sent down to the PCI Express graphics port, kept on the internal backbone, or left unclaimed. It covers only the legacy display address windows. The first is the monochrome adapter range. The second is the VGA range, which surrounds and overlaps the monochrome range.

A monochrome-present setting divides the two windows between the graphics port and the backbone. I/O decoding uses only the low ten address bits, so each 1 KB alias of a legacy port also matches. The decision is taken per byte lane from the byte enables.

The result is registered and appears one clock after the request. A request outside every legacy window is reported as not claimed, and is kept apart from a backbone decision. This lets an outer bridge decoder apply its own general windows to that request. A configuration that sets monochrome-present without VGA enable is flagged as illegal and is routed as though neither bit were set.

Top module: `legacy_route_dec`

## Requirements
- R1: A request taken while `req_valid_i` is high produces `rsp_valid_o`=1 together with its route and illegal flag on the next clock. In a cycle with no request, and under reset, `rsp_valid_o`, `rsp_route_o` and `rsp_illegal_o` are all 0.
- R2: Route codes are 0 = not claimed, 1 = backbone, 2 = graphics port. A memory request with an address outside 0x0A0000..0x0BFFFF (full address compared) is not claimed.
- R3: With VGA enable 0 and monochrome-present 0, every legacy memory or I/O reference routes to the backbone (1) and the illegal flag is 0.
- R4: With VGA enable 0 and monochrome-present 1, the illegal flag is 1 and routing is the same as in R3.
- R5: With VGA enable 1 and monochrome-present 0, VGA and monochrome memory and I/O references route to the graphics port (2), subject to R9 and R10.
- R6: With VGA enable 1 and monochrome-present 1, the following route to the backbone: memory at 0x0B0000..0x0B7FFF, and I/O at ports 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh. Other VGA references go to the graphics port. The remaining VGA references are memory at 0x0A0000..0x0BFFFF and I/O at 3B0h..3BBh and 3C0h..3DFh.
- R7: For I/O, byte lane k (byte-enable bit k) addresses {addr[15:2],k}. Address bits 15..10 are ignored when matching legacy ports.
- R8: With monochrome-present in effect, an I/O request whose enabled bytes include any monochrome port routes to the backbone, even if its other bytes are VGA ports.
- R9: With VGA enable 1 and monochrome-present 0, an I/O request touching 3BCh..3BFh goes to the port only when {addr[15:2],2'b00} lies within io base..io limit inclusive. Otherwise it routes to the backbone.
- R10: A legacy memory request routes to the backbone instead of the port when memory access enable is 0. A legacy I/O request routes to the backbone instead of the port when I/O access enable is 0.
- R11: An I/O request with no enabled byte in 3B0h..3BFh or 3C0h..3DFh (after aliasing) is not claimed. This includes a request with all byte enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_is_io_i | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr_i | input | ADDR_W | Request address |
| req_be_i | input | BE_W | Byte enables for I/O lanes |
| cfg_vga_en_i | input | 1 | VGA window enable |
| cfg_mda_i | input | 1 | Monochrome adapter present |
| cfg_mem_en_i | input | 1 | Memory access enable |
| cfg_io_en_i | input | 1 | I/O access enable |
| cfg_io_base_i | input | 16 | I/O window base |
| cfg_io_limit_i | input | 16 | I/O window limit |
| rsp_valid_o | output | 1 | Decision valid |
| rsp_route_o | output | 2 | Route code |
| rsp_illegal_o | output | 1 | Illegal configuration flag |

## Verification
Every decision is due exactly one clock after its request. The bench drives a request on a falling edge and holds it through one rising edge. It then drops valid and samples all three outputs at the next falling edge, when the registered result is stable. The same sample also shows the idle zero state for the cycle that follows. Configuration inputs are changed only between requests, so each decision depends on a single, known setting.

// File: rtl/legacy_route_pkg.sv
package legacy_route_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE     = 2'd0,
    ROUTE_BACKBONE = 2'd1,
    ROUTE_PORT     = 2'd2
  } route_e;
endpackage

// File: rtl/legacy_io_lane.sv
module legacy_io_lane (
  input  logic [9:0] port_i,
  output logic       mono_o,
  output logic       vga_o,
  output logic       hi_o
);
  always_comb begin
    mono_o = (port_i == 10'h3B4) || (port_i == 10'h3B5) || (port_i == 10'h3B8) ||
             (port_i == 10'h3B9) || (port_i == 10'h3BA) || (port_i == 10'h3BF);
    vga_o  = ((port_i >= 10'h3B0) && (port_i <= 10'h3BB)) ||
             ((port_i >= 10'h3C0) && (port_i <= 10'h3DF));
    hi_o   = (port_i >= 10'h3BC) && (port_i <= 10'h3BF);
  end
endmodule

// File: rtl/legacy_mem_win.sv
module legacy_mem_win #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vga_o,
  output logic              mono_o
);
  localparam logic [ADDR_W-1:0] VgaLo  = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] VgaHi  = ADDR_W'(32'h000B_FFFF);
  localparam logic [ADDR_W-1:0] MonoLo = ADDR_W'(32'h000B_0000);
  localparam logic [ADDR_W-1:0] MonoHi = ADDR_W'(32'h000B_7FFF);

  always_comb begin
    vga_o  = (addr_i >= VgaLo) && (addr_i <= VgaHi);
    mono_o = (addr_i >= MonoLo) && (addr_i <= MonoHi);
  end
endmodule

// File: rtl/legacy_route_sel.sv
module legacy_route_sel
  import legacy_route_pkg::*;
(
  input  logic   is_io_i,
  input  logic   mem_vga_i,
  input  logic   mem_mono_i,
  input  logic   io_any_i,
  input  logic   io_mono_i,
  input  logic   io_hi_i,
  input  logic   io_in_win_i,
  input  logic   vga_en_i,
  input  logic   mda_i,
  input  logic   mem_en_i,
  input  logic   io_en_i,
  output route_e route_o,
  output logic   illegal_o
);
  logic vga_eff, mono_eff;

  always_comb begin
    illegal_o = !vga_en_i && mda_i;
    vga_eff   = vga_en_i;
    mono_eff  = vga_en_i && mda_i;
    route_o   = ROUTE_NONE;
    if (!is_io_i) begin
      if (!mem_vga_i)                  route_o = ROUTE_NONE;
      else if (!vga_eff)               route_o = ROUTE_BACKBONE;
      else if (mono_eff && mem_mono_i) route_o = ROUTE_BACKBONE;
      else if (!mem_en_i)              route_o = ROUTE_BACKBONE;
      else                             route_o = ROUTE_PORT;
    end else begin
      if (!io_any_i)                   route_o = ROUTE_NONE;
      else if (!vga_eff)               route_o = ROUTE_BACKBONE;
      else if (mono_eff && io_mono_i)  route_o = ROUTE_BACKBONE;
      // upper monochrome dword only forwarded through the I/O window
      else if (io_hi_i && (mono_eff || !io_in_win_i)) route_o = ROUTE_BACKBONE;
      else if (!io_en_i)               route_o = ROUTE_BACKBONE;
      else                             route_o = ROUTE_PORT;
    end
  end
endmodule

// File: rtl/legacy_route_dec.sv
module legacy_route_dec
  import legacy_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_is_io_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic              cfg_vga_en_i,
  input  logic              cfg_mda_i,
  input  logic              cfg_mem_en_i,
  input  logic              cfg_io_en_i,
  input  logic [15:0]       cfg_io_base_i,
  input  logic [15:0]       cfg_io_limit_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_route_o,
  output logic              rsp_illegal_o
);
  localparam int LaneW = $clog2(BE_W);

  logic [BE_W-1:0] lane_mono, lane_vga, lane_hi;
  logic            mem_vga, mem_mono;
  logic            io_any, io_mono, io_hi, io_in_win;
  logic [15:0]     io_dword;
  route_e          route_d;
  logic            illegal_d;

  for (genvar k = 0; k < BE_W; k++) begin : g_lane
    logic [9:0] lane_port;
    assign lane_port = {req_addr_i[9:LaneW], LaneW'(k)};
    legacy_io_lane u_lane (
      .port_i (lane_port),
      .mono_o (lane_mono[k]),
      .vga_o  (lane_vga[k]),
      .hi_o   (lane_hi[k])
    );
  end

  legacy_mem_win #(.ADDR_W(ADDR_W)) u_mem (
    .addr_i (req_addr_i),
    .vga_o  (mem_vga),
    .mono_o (mem_mono)
  );

  always_comb begin
    io_dword  = {req_addr_i[15:LaneW], LaneW'(0)};
    io_mono   = |(lane_mono & req_be_i);
    io_hi     = |(lane_hi & req_be_i);
    io_any    = |((lane_vga | lane_hi) & req_be_i);
    io_in_win = (io_dword >= cfg_io_base_i) && (io_dword <= cfg_io_limit_i);
  end

  legacy_route_sel u_sel (
    .is_io_i     (req_is_io_i),
    .mem_vga_i   (mem_vga),
    .mem_mono_i  (mem_mono),
    .io_any_i    (io_any),
    .io_mono_i   (io_mono),
    .io_hi_i     (io_hi),
    .io_in_win_i (io_in_win),
    .vga_en_i    (cfg_vga_en_i),
    .mda_i       (cfg_mda_i),
    .mem_en_i    (cfg_mem_en_i),
    .io_en_i     (cfg_io_en_i),
    .route_o     (route_d),
    .illegal_o   (illegal_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_route_o   <= 2'd0;
      rsp_illegal_o <= 1'b0;
    end else if (req_valid_i) begin
      rsp_valid_o   <= 1'b1;
      rsp_route_o   <= route_d;
      rsp_illegal_o <= illegal_d;
    end else begin
      rsp_valid_o   <= 1'b0;
      rsp_route_o   <= 2'd0;
      rsp_illegal_o <= 1'b0;
    end
  end
endmodule

// File: rtl/legacy_route_checker.sv
module legacy_route_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_is_io_i,
  input logic       cfg_vga_en_i,
  input logic       cfg_mda_i,
  input logic       cfg_mem_en_i,
  input logic       cfg_io_en_i,
  input logic       rsp_valid_o,
  input logic [1:0] rsp_route_o,
  input logic       rsp_illegal_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_route_o == 2'd0) && !rsp_illegal_o); // R1
  AST_ROUTE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_route_o != 2'd3); // R2
  AST_VGA_OFF_NO_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cfg_vga_en_i) |=> rsp_route_o != 2'd2); // R3
  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_illegal_o == $past(!cfg_vga_en_i && cfg_mda_i)); // R4
  AST_MEM_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_is_io_i && !cfg_mem_en_i) |=> rsp_route_o != 2'd2); // R10
  AST_IO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_io_i && !cfg_io_en_i) |=> rsp_route_o != 2'd2); // R10
endmodule

bind legacy_route_dec legacy_route_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_is_io_i   (req_is_io_i),
  .cfg_vga_en_i  (cfg_vga_en_i),
  .cfg_mda_i     (cfg_mda_i),
  .cfg_mem_en_i  (cfg_mem_en_i),
  .cfg_io_en_i   (cfg_io_en_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_route_o   (rsp_route_o),
  .rsp_illegal_o (rsp_illegal_o)
);

// File: tb/legacy_route_dec_bench.sv
module legacy_route_dec_bench;
  localparam int CLK_P = 10;
  localparam logic [1:0] NONE = 2'd0, BB = 2'd1, PORT = 2'd2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_is_io_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [3:0]  req_be_i = '0;
  logic        cfg_vga_en_i = 1'b1, cfg_mda_i = 1'b0;
  logic        cfg_mem_en_i = 1'b1, cfg_io_en_i = 1'b1;
  logic [15:0] cfg_io_base_i = 16'h0000, cfg_io_limit_i = 16'hFFFF;
  logic        rsp_valid_o, rsp_illegal_o;
  logic [1:0]  rsp_route_o;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  legacy_route_dec u_legacy_route_dec (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(logic vga, logic mda, logic men, logic ien);
    cfg_vga_en_i = vga; cfg_mda_i = mda; cfg_mem_en_i = men; cfg_io_en_i = ien;
  endtask

  task automatic req(string r, logic io, logic [31:0] a, logic [3:0] be,
                     logic [1:0] exp_rt, logic exp_ill);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_is_io_i = io; req_addr_i = a; req_be_i = be;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(r, "valid", int'(rsp_valid_o), 1);
    chk(r, "route", int'(rsp_route_o), int'(exp_rt));
    chk(r, "illegal", int'(rsp_illegal_o), int'(exp_ill));
  endtask

  task automatic t_reset_idle();
    chk("R1", "reset valid", int'(rsp_valid_o), 0);
    chk("R1", "reset route", int'(rsp_route_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "idle valid", int'(rsp_valid_o), 0);
    chk("R1", "idle illegal", int'(rsp_illegal_o), 0);
  endtask

  task automatic t_mem_window();
    cfg(1, 0, 1, 1);
    req("R2", 0, 32'h000C_0000, 4'h0, NONE, 0);
    req("R2", 0, 32'h0009_FFFF, 4'h0, NONE, 0);
    req("R2", 0, 32'h010A_0000, 4'h0, NONE, 0);
    req("R5", 0, 32'h000A_0000, 4'h0, PORT, 0);
    req("R5", 0, 32'h000B_FFFF, 4'h0, PORT, 0);
    @(negedge clk_i);
    chk("R1", "gap valid", int'(rsp_valid_o), 0);
    chk("R1", "gap route", int'(rsp_route_o), 0);
  endtask

  task automatic t_vga_off();
    cfg(0, 0, 1, 1);
    req("R3", 0, 32'h000B_0000, 4'h0, BB, 0);
    req("R3", 1, 32'h0000_03D4, 4'h1, BB, 0);
    cfg(0, 1, 1, 1);
    req("R4", 0, 32'h000A_0000, 4'h0, BB, 1);
    req("R4", 1, 32'h0000_03C0, 4'h1, BB, 1);
    req("R4", 0, 32'h000C_0000, 4'h0, NONE, 1);
  endtask

  task automatic t_mono_absent();
    cfg(1, 0, 1, 1);
    req("R5", 0, 32'h000B_0000, 4'h0, PORT, 0);
    req("R5", 1, 32'h0000_03B4, 4'h1, PORT, 0);
    req("R7", 1, 32'h0000_07D4, 4'h1, PORT, 0);
  endtask

  task automatic t_mono_present();
    cfg(1, 1, 1, 1);
    req("R6", 0, 32'h000B_7FFF, 4'h0, BB, 0);
    req("R6", 0, 32'h000B_8000, 4'h0, PORT, 0);
    req("R6", 1, 32'h0000_03C0, 4'h1, PORT, 0);
    req("R6", 1, 32'h0000_03B4, 4'h1, BB, 0);
    req("R7", 1, 32'h0000_FFB4, 4'h1, BB, 0);
    req("R7", 1, 32'h0000_03B4, 4'h4, PORT, 0);
    req("R8", 1, 32'h0000_03B8, 4'hF, BB, 0);
    req("R8", 1, 32'h0000_03B4, 4'hE, BB, 0);
    req("R8", 1, 32'h0000_03B0, 4'hF, PORT, 0);
  endtask

  task automatic t_hi_window();
    cfg(1, 0, 1, 1);
    cfg_io_base_i = 16'h0300; cfg_io_limit_i = 16'h03FF;
    req("R9", 1, 32'h0000_03BC, 4'h1, PORT, 0);
    req("R9", 1, 32'h0000_07BC, 4'h8, BB, 0);
    cfg_io_base_i = 16'h0400; cfg_io_limit_i = 16'h0FFF;
    req("R9", 1, 32'h0000_03BC, 4'h1, BB, 0);
    req("R9", 1, 32'h0000_07BC, 4'h8, PORT, 0);
    cfg_io_base_i = 16'h0000; cfg_io_limit_i = 16'h03BC;
    req("R9", 1, 32'h0000_03BC, 4'h2, PORT, 0);
    cfg_io_limit_i = 16'hFFFF;
  endtask

  task automatic t_enables();
    cfg(1, 0, 0, 1);
    req("R10", 0, 32'h000A_0000, 4'h0, BB, 0);
    req("R10", 1, 32'h0000_03C0, 4'h1, PORT, 0);
    cfg(1, 0, 1, 0);
    req("R10", 1, 32'h0000_03C0, 4'h1, BB, 0);
    req("R10", 0, 32'h000A_0000, 4'h0, PORT, 0);
  endtask

  task automatic t_io_unclaimed();
    cfg(1, 0, 1, 1);
    req("R11", 1, 32'h0000_03E0, 4'h1, NONE, 0);
    req("R11", 1, 32'h0000_03C0, 4'h0, NONE, 0);
    req("R11", 1, 32'h0000_02F8, 4'hF, NONE, 0);
    req("R11", 1, 32'h0000_03AC, 4'hF, NONE, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P/4);
    t_reset_idle();
    t_mem_window();
    t_vga_off();
    t_mono_absent();
    t_mono_present();
    t_hi_window();
    t_enables();
    t_io_unclaimed();
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule